// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block brings a freshly inserted SD card from power-up to the transfer state with no software in the loop. After a `start` pulse it waits a fixed number of clocks at the slow identification clock. It then issues the bring-up commands one at a time through a request/acknowledge port to a separate command engine. That engine owns the CMD line, the CRC and the response timing. The sequencer decides what to send next from each response.

The block tells newer (v2) cards from older ones by the echo of the interface-condition check. It polls the operating-condition command until the card reports ready, and gives up after a limit counted in millisecond ticks. It captures the operating conditions, the card identity, the relative address and the card-specific data. From the speed byte of the card-specific data it picks a half-rate or quarter-rate operating clock. Finally it selects the card.

Completion is a one-cycle `done` pulse. The accompanying `err_code` names the step that failed, or is zero on success.

Top module: `sd_ident_seq`

## Requirements
- R1: After an accepted `start`, no command is requested for at least `PRE_WAIT_CYC` clocks, and `clk_sel` reads 0 (identification clock) from `start` until the card-specific data has been captured.
- R2: The first command is index 0 with argument 0 and response kind 0 (none). If it is acknowledged with `cmd_ok`=0, the run ends with `err_code`=1.
- R3: The second command is index 8 with argument 0x1AA and response kind 1 (short). `card_v2` is set only when `cmd_ok`=1 and `cmd_rsp[11:0]`=0x1AA. A missing or mismatched echo means a v1 card and is not an error.
- R4: Index 55 (argument 0, short) and index 41 (short) repeat as a pair until `cmd_rsp[31]` of an acknowledged index-41 reply is 1. The index-41 argument is 0x00FF8000, with bit 30 set exactly when `card_v2` is 1. A failed index 55 or index 41 does not end the run.
- R5: Once `TIMEOUT_MS` rising `ms_tick` pulses have been counted since the poll began, the next index-41 reply that is not ready ends the run with `err_code`=2. A ready reply that arrives after expiry still succeeds.
- R6: Each successful index-41 reply is stored in `card_ocr`. `card_hc` takes bit 30 of the reply that reports ready.
- R7: Index 2 (argument 0, kind 2 long) stores `cmd_rsp` in `card_cid`, and a failure gives `err_code`=3. Index 3 (argument 0, short) stores `cmd_rsp[31:16]` in `card_rca`, and a failure gives `err_code`=4.
- R8: Index 9 (argument {rca,16'h0}, long) stores `cmd_rsp` in `card_csd`, and a failure gives `err_code`=5. On success, `clk_sel` becomes 1 (source/2) if `cmd_rsp[103:96]`=0x5A, otherwise 2 (source/4).
- R9: Index 7 (argument {rca,16'h0}, short) follows, requested only after `clk_sel` has left 0. A failure gives `err_code`=6, and success gives `err_code`=0.
- R10: `done` is high for exactly one cycle per accepted `start`. `err_code` holds until the next start, and a `start` while a run is in progress is ignored.
- R11: `cmd_idx`, `cmd_arg` and `cmd_rsp_kind` stay stable while `cmd_req` is high, until the cycle in which `cmd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (accepted when idle) |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 3 | 0 success, otherwise failing step (1..6) |
| cmd_req | output | 1 | Command request to the engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_kind | output | 2 | 0 none, 1 short, 2 long |
| cmd_ack | input | 1 | Engine finished the requested command |
| cmd_ok | input | 1 | Command sent / response received intact |
| cmd_rsp | input | 128 | Response payload; short replies in [31:0] |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| clk_sel | output | 2 | 0 identification, 1 source/2, 2 source/4 |
| card_v2 | output | 1 | Card answered the interface-condition check |
| card_hc | output | 1 | High-capacity flag from the ready reply |
| card_ocr | output | 32 | Last operating-conditions reply |
| card_cid | output | 128 | Card identity |
| card_rca | output | 16 | Relative card address |
| card_csd | output | 128 | Card-specific data |

## Verification
The poll limit and the card's ready indication can meet in the same acknowledge cycle. This happens when the limit has already expired while an index-41 reply is outstanding. The bench provokes it by stretching the engine's answer to that command beyond the tick count while ticks run every cycle. A ready reply in that situation must complete the run with code 0. A not-ready reply must end it with code 2. A second overlap is a stray `start` arriving in the middle of a run, and it is judged by counting exactly one `done` pulse.

// File: rtl/sd_ident_pkg.sv
package sd_ident_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_WAIT, S_C0, S_C8, S_C55, S_A41,
        S_C2, S_C3, S_C9, S_C7, S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_SHORT = 2'd1,
        RK_LONG  = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CK_IDENT   = 2'd0,
        CK_HALF    = 2'd1,
        CK_QUARTER = 2'd2
    } clk_sel_e;

    typedef enum logic [2:0] {
        E_NONE   = 3'd0,
        E_RESET  = 3'd1,
        E_OPCOND = 3'd2,
        E_CID    = 3'd3,
        E_RCA    = 3'd4,
        E_CSD    = 3'd5,
        E_SELECT = 3'd6
    } err_e;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        rsp_kind_e   kind;
    } cmd_t;

    localparam logic [11:0] IF_ECHO     = 12'h1AA;
    localparam logic [31:0] VOLT_WINDOW = 32'h00FF_8000;
    localparam int          HCS_BIT     = 30;
    localparam int          READY_BIT   = 31;
    localparam int          SPEED_LSB   = 96;
    localparam logic [7:0]  SPEED_50M   = 8'h5A;

    function automatic clk_sel_e pick_clock(input logic [7:0] speed);
        return (speed == SPEED_50M) ? CK_HALF : CK_QUARTER;
    endfunction

endpackage

// File: rtl/sd_ident_prewait.sv
module sd_ident_prewait #(
    parameter int CYCLES = 148
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic elapsed
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!elapsed)
            cnt <= cnt + 1'b1;
    end

    assign elapsed = (cnt == CW'(CYCLES));

    // R1: once elapsed, the count stays put for as long as the wait runs
    a_r1_elapsed_holds: assert property (@(posedge clk) disable iff (rst)
        elapsed && run |=> elapsed || !run);

endmodule

// File: rtl/sd_ident_poll_timer.sv
module sd_ident_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick && !expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == TW'(LIMIT));

    // R5: expiry is sticky until the poll is restarted
    a_r5_expiry_sticky: assert property (@(posedge clk) disable iff (rst)
        expired && !clear |=> expired);

endmodule

// File: rtl/sd_ident_cmdgen.sv
module sd_ident_cmdgen
    import sd_ident_pkg::*;
(
    input  seq_state_e  state,
    input  logic        v2,
    input  logic [15:0] rca,
    output cmd_t        cmd,
    output logic        active
);
    always_comb begin
        cmd    = '0;
        active = 1'b1;
        unique case (state)
            S_C0:  cmd = '{idx: 6'd0,  arg: 32'h0, kind: RK_NONE};
            S_C8:  cmd = '{idx: 6'd8,  arg: {20'h0, IF_ECHO}, kind: RK_SHORT};
            S_C55: cmd = '{idx: 6'd55, arg: 32'h0, kind: RK_SHORT};
            S_A41: begin
                cmd = '{idx: 6'd41, arg: VOLT_WINDOW, kind: RK_SHORT};
                cmd.arg[HCS_BIT] = v2;
            end
            S_C2:  cmd = '{idx: 6'd2,  arg: 32'h0, kind: RK_LONG};
            S_C3:  cmd = '{idx: 6'd3,  arg: 32'h0, kind: RK_SHORT};
            S_C9:  cmd = '{idx: 6'd9,  arg: {rca, 16'h0}, kind: RK_LONG};
            S_C7:  cmd = '{idx: 6'd7,  arg: {rca, 16'h0}, kind: RK_SHORT};
            default: active = 1'b0;
        endcase
    end
endmodule

// File: rtl/sd_ident_seq.sv
module sd_ident_seq
    import sd_ident_pkg::*;
#(
    parameter int PRE_WAIT_CYC = 148,
    parameter int TIMEOUT_MS   = 1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         done,
    output logic [2:0]   err_code,
    output logic         cmd_req,
    output logic [5:0]   cmd_idx,
    output logic [31:0]  cmd_arg,
    output logic [1:0]   cmd_rsp_kind,
    input  logic         cmd_ack,
    input  logic         cmd_ok,
    input  logic [127:0] cmd_rsp,
    input  logic         ms_tick,
    output logic [1:0]   clk_sel,
    output logic         card_v2,
    output logic         card_hc,
    output logic [31:0]  card_ocr,
    output logic [127:0] card_cid,
    output logic [15:0]  card_rca,
    output logic [127:0] card_csd
);
    seq_state_e state;
    err_e       err_q;
    clk_sel_e   clk_q;
    cmd_t       cmd;
    logic       cmd_active;
    logic       wait_done;
    logic       poll_expired;
    logic       poll_clear;

    sd_ident_prewait #(.CYCLES(PRE_WAIT_CYC)) u_prewait (
        .clk     (clk),
        .rst     (rst),
        .run     (state == S_WAIT),
        .elapsed (wait_done)
    );

    assign poll_clear = (state == S_C8) && cmd_ack;

    sd_ident_poll_timer #(.LIMIT(TIMEOUT_MS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (poll_clear),
        .tick    (ms_tick),
        .expired (poll_expired)
    );

    sd_ident_cmdgen u_cmdgen (
        .state  (state),
        .v2     (card_v2),
        .rca    (card_rca),
        .cmd    (cmd),
        .active (cmd_active)
    );

    assign cmd_req      = cmd_active;
    assign cmd_idx      = cmd.idx;
    assign cmd_arg      = cmd.arg;
    assign cmd_rsp_kind = cmd.kind;
    assign err_code     = err_q;
    assign clk_sel      = clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            err_q    <= E_NONE;
            clk_q    <= CK_IDENT;
            done     <= 1'b0;
            card_v2  <= 1'b0;
            card_hc  <= 1'b0;
            card_ocr <= '0;
            card_cid <= '0;
            card_rca <= '0;
            card_csd <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    state   <= S_WAIT;
                    err_q   <= E_NONE;
                    clk_q   <= CK_IDENT;
                    card_v2 <= 1'b0;
                    card_hc <= 1'b0;
                end
                S_WAIT: if (wait_done) state <= S_C0;
                S_C0: if (cmd_ack) begin
                    if (cmd_ok) state <= S_C8;
                    else begin err_q <= E_RESET; state <= S_FIN; end
                end
                S_C8: if (cmd_ack) begin
                    card_v2 <= cmd_ok && (cmd_rsp[11:0] == IF_ECHO);
                    state   <= S_C55;
                end
                S_C55: if (cmd_ack) state <= S_A41;
                S_A41: if (cmd_ack) begin
                    if (cmd_ok) card_ocr <= cmd_rsp[31:0];
                    if (cmd_ok && cmd_rsp[READY_BIT]) begin
                        card_hc <= cmd_rsp[HCS_BIT];
                        state   <= S_C2;
                    end else if (poll_expired) begin
                        err_q <= E_OPCOND;
                        state <= S_FIN;
                    end else begin
                        state <= S_C55;
                    end
                end
                S_C2: if (cmd_ack) begin
                    if (cmd_ok) begin card_cid <= cmd_rsp; state <= S_C3; end
                    else begin err_q <= E_CID; state <= S_FIN; end
                end
                S_C3: if (cmd_ack) begin
                    if (cmd_ok) begin card_rca <= cmd_rsp[31:16]; state <= S_C9; end
                    else begin err_q <= E_RCA; state <= S_FIN; end
                end
                S_C9: if (cmd_ack) begin
                    if (cmd_ok) begin
                        card_csd <= cmd_rsp;
                        clk_q    <= pick_clock(cmd_rsp[SPEED_LSB +: 8]);
                        state    <= S_C7;
                    end else begin
                        err_q <= E_CSD;
                        state <= S_FIN;
                    end
                end
                S_C7: if (cmd_ack) begin
                    if (!cmd_ok) err_q <= E_SELECT;
                    state <= S_FIN;
                end
                S_FIN: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Checker: clocks elapsed since the run left idle (saturating)
    localparam int SW = $clog2(PRE_WAIT_CYC + 2) + 1;
    logic [SW-1:0] since_go;
    always_ff @(posedge clk) begin
        if (rst || state == S_IDLE)
            since_go <= '0;
        else if (since_go != '1)
            since_go <= since_go + 1'b1;
    end

    a_r1_no_early_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> since_go >= SW'(PRE_WAIT_CYC));

    a_r1_ident_clock: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_idx != 6'd7 |-> clk_sel == 2'd0);

    a_r9_select_after_switch: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_idx == 6'd7 |-> clk_sel != 2'd0);

    a_r4_hcs_tracks_v2: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_idx == 6'd41 |-> cmd_arg[HCS_BIT] == card_v2);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_success_clocked: assert property (@(posedge clk) disable iff (rst)
        done && err_code == 3'd0 |-> clk_sel != 2'd0);

    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_idx) && $stable(cmd_arg)
                                && $stable(cmd_rsp_kind));

endmodule

// File: tb/sd_ident_seq_tb_top.sv
module sd_ident_seq_tb_top;
    localparam int PRE = 148;
    localparam int TMO = 1000;
    localparam logic [15:0] RCA = 16'hB35C;
    localparam logic [127:0] CID = 128'h035344_5355313647_80_1234ABCD_0136_7F;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         done;
    logic [2:0]   err_code;
    logic         cmd_req;
    logic [5:0]   cmd_idx;
    logic [31:0]  cmd_arg;
    logic [1:0]   cmd_rsp_kind;
    logic         cmd_ack = 1'b0;
    logic         cmd_ok = 1'b0;
    logic [127:0] cmd_rsp = '0;
    logic         ms_tick = 1'b0;
    logic [1:0]   clk_sel;
    logic         card_v2, card_hc;
    logic [31:0]  card_ocr;
    logic [127:0] card_cid, card_csd;
    logic [15:0]  card_rca;

    always #5 clk = ~clk;

    sd_ident_seq #(.PRE_WAIT_CYC(PRE), .TIMEOUT_MS(TMO)) dut_i (
        .clk(clk), .rst(rst), .start(start), .done(done), .err_code(err_code),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_rsp_kind(cmd_rsp_kind), .cmd_ack(cmd_ack), .cmd_ok(cmd_ok),
        .cmd_rsp(cmd_rsp), .ms_tick(ms_tick), .clk_sel(clk_sel),
        .card_v2(card_v2), .card_hc(card_hc), .card_ocr(card_ocr),
        .card_cid(card_cid), .card_rca(card_rca), .card_csd(card_csd)
    );

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    bit tick_en = 1'b0;

    typedef struct {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [1:0]  kind;
    } exp_t;
    exp_t exp_q[$];

    // engine configuration for the running scenario
    bit          cfg_c8_ok;
    logic [31:0] cfg_c8_val;
    int          cfg_polls;
    bit          cfg_first_bad;
    logic [31:0] cfg_ocr;
    logic [127:0] cfg_csd;
    int          cfg_fail_idx;
    bit          cfg_slow41;
    logic [1:0]  cfg_clk;
    int          poll_n;

    task automatic chk(input string req, input string what, input bit pass,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!pass) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] i, input logic [31:0] a, input logic [1:0] k);
        exp_t e;
        e.idx = i; e.arg = a; e.kind = k;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (done) done_cnt++;
        ms_tick <= tick_en;
    end

    // Monitor + command engine model: pops the expected item per request
    initial begin : engine
        forever begin
            @(negedge clk);
            if (cmd_req) begin
                exp_t e;
                logic [5:0] idx;
                int lat;
                idx = cmd_idx;
                if (exp_q.size() == 0) begin
                    chk("R11", "unexpected command", 1'b0, 128'(cmd_idx), 128'h3f);
                end else begin
                    e = exp_q.pop_front();
                    chk("R4", "command index", cmd_idx == e.idx, 128'(cmd_idx), 128'(e.idx));
                    chk("R3", "command argument", cmd_arg == e.arg, 128'(cmd_arg), 128'(e.arg));
                    chk("R7", "response kind", cmd_rsp_kind == e.kind,
                        128'(cmd_rsp_kind), 128'(e.kind));
                    chk(idx == 6'd7 ? "R9" : "R1", "clock select at request",
                        clk_sel == (idx == 6'd7 ? cfg_clk : 2'd0),
                        128'(clk_sel), 128'(idx == 6'd7 ? cfg_clk : 2'd0));
                end
                lat = (idx == 6'd41 && cfg_slow41) ? TMO + 100 : 2;
                repeat (lat) @(negedge clk);
                cmd_ok  = (int'(idx) != cfg_fail_idx);
                cmd_rsp = 128'h0000_0120;
                case (idx)
                    6'd8: begin cmd_ok = cfg_c8_ok; cmd_rsp = 128'(cfg_c8_val); end
                    6'd41: begin
                        if (poll_n < cfg_polls) begin
                            cmd_rsp = 128'(32'h00FF_8000);
                            if (poll_n == 0 && cfg_first_bad) cmd_ok = 1'b0;
                        end else begin
                            cmd_rsp = 128'(cfg_ocr);
                        end
                        poll_n++;
                    end
                    6'd2: cmd_rsp = CID;
                    6'd3: cmd_rsp = 128'({RCA, 16'h0520});
                    6'd9: cmd_rsp = cfg_csd;
                    default: ;
                endcase
                cmd_ack = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0;
                cmd_ok  = 1'b0;
            end
        end
    end

    task automatic scenario(input string name, input bit c8_ok, input logic [31:0] c8_val,
                            input int polls, input bit first_bad, input logic [31:0] ocr,
                            input logic [7:0] speed, input int fail_idx, input bit slow41,
                            input bit poke, input logic [2:0] exp_err, input bit exp_v2,
                            input bit exp_hc, input logic [1:0] exp_clk);
        int lat;
        int waited;
        cfg_c8_ok = c8_ok; cfg_c8_val = c8_val; cfg_polls = polls;
        cfg_first_bad = first_bad; cfg_ocr = ocr; cfg_fail_idx = fail_idx;
        cfg_slow41 = slow41; cfg_clk = exp_clk; poll_n = 0;
        tick_en = slow41;
        cfg_csd = {24'h400E00, speed, 32'h5B5901D7, 32'h1B7F800A, 32'h40000001};
        exp_q.delete();
        push(6'd0, 32'h0, 2'd0);
        if (fail_idx != 0) begin
            push(6'd8, 32'h1AA, 2'd1);
            for (int i = 0; i <= polls; i++) begin
                if (!(slow41 && exp_err == 3'd2 && i > 0)) begin
                    push(6'd55, 32'h0, 2'd1);
                    push(6'd41, 32'h00FF_8000 | (exp_v2 ? 32'h4000_0000 : 32'h0), 2'd1);
                end
            end
            if (exp_err != 3'd2) begin
                push(6'd2, 32'h0, 2'd2);
                if (fail_idx != 2) begin
                    push(6'd3, 32'h0, 2'd1);
                    if (fail_idx != 3) begin
                        push(6'd9, {RCA, 16'h0}, 2'd2);
                        if (fail_idx != 9) push(6'd7, {RCA, 16'h0}, 2'd1);
                    end
                end
            end
        end
        done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 1;
        while (!cmd_req && lat < 5000) begin @(negedge clk); lat++; end
        chk("R1", {name, " pre-wait length"}, lat >= PRE && lat <= PRE + 3,
            128'(lat), 128'(PRE));
        waited = 0;
        while (done_cnt == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 20) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        chk("R10", {name, " done pulses"}, done_cnt == 1, 128'(done_cnt), 128'd1);
        chk("R2", {name, " error code"}, err_code == exp_err, 128'(err_code), 128'(exp_err));
        chk("R2", {name, " all commands issued"}, exp_q.size() == 0,
            128'(exp_q.size()), 128'd0);
        chk("R3", {name, " v2 flag"}, card_v2 == exp_v2, 128'(card_v2), 128'(exp_v2));
        chk("R8", {name, " clock select"}, clk_sel == exp_clk, 128'(clk_sel), 128'(exp_clk));
        if (exp_err == 3'd0) begin
            chk("R6", {name, " hc flag"}, card_hc == exp_hc, 128'(card_hc), 128'(exp_hc));
            chk("R6", {name, " ocr"}, card_ocr == ocr, 128'(card_ocr), 128'(ocr));
            chk("R7", {name, " cid"}, card_cid == CID, card_cid, CID);
            chk("R7", {name, " rca"}, card_rca == RCA, 128'(card_rca), 128'(RCA));
            chk("R8", {name, " csd"}, card_csd == cfg_csd, card_csd, cfg_csd);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset done", done == 1'b0, 128'(done), 128'd0);
        chk("R11", "reset request", cmd_req == 1'b0, 128'(cmd_req), 128'd0);
        chk("R1", "reset clock select", clk_sel == 2'd0, 128'(clk_sel), 128'd0);
        chk("R10", "reset error code", err_code == 3'd0, 128'(err_code), 128'd0);

        // v2 high-capacity 50 MHz card, first poll reply lost, stray start mid-run
        scenario("v2hc", 1'b1, 32'h1AA, 2, 1'b1, 32'hC0FF_8000, 8'h5A, -1, 1'b0, 1'b1,
                 3'd0, 1'b1, 1'b1, 2'd1);
        // v1 card: no echo, standard speed
        scenario("v1", 1'b0, 32'h0, 0, 1'b0, 32'h80FF_8000, 8'h32, -1, 1'b0, 1'b0,
                 3'd0, 1'b0, 1'b0, 2'd2);
        // echo mismatch in the low 12 bits -> v1, fast speed byte
        scenario("badecho", 1'b1, 32'h1AB, 1, 1'b0, 32'h80FF_8000, 8'h5A, -1, 1'b0, 1'b0,
                 3'd0, 1'b0, 1'b0, 2'd1);
        // v2 standard-capacity, upper echo bits ignored
        scenario("v2sc", 1'b1, 32'hF1AA, 0, 1'b0, 32'h80FF_8000, 8'h32, -1, 1'b0, 1'b0,
                 3'd0, 1'b1, 1'b0, 2'd2);
        // R5 timeout: not-ready reply after expiry
        scenario("timeout", 1'b1, 32'h1AA, 1, 1'b0, 32'hC0FF_8000, 8'h5A, -1, 1'b1, 1'b0,
                 3'd2, 1'b1, 1'b0, 2'd0);
        // R5 race: ready reply after expiry still succeeds
        scenario("lateready", 1'b1, 32'h1AA, 0, 1'b0, 32'hC0FF_8000, 8'h5A, -1, 1'b1, 1'b0,
                 3'd0, 1'b1, 1'b1, 2'd1);
        // failing steps
        scenario("fail0", 1'b1, 32'h1AA, 0, 1'b0, 32'hC0FF_8000, 8'h5A, 0, 1'b0, 1'b0,
                 3'd1, 1'b0, 1'b0, 2'd0);
        scenario("fail2", 1'b1, 32'h1AA, 0, 1'b0, 32'hC0FF_8000, 8'h5A, 2, 1'b0, 1'b0,
                 3'd3, 1'b1, 1'b0, 2'd0);
        scenario("fail3", 1'b1, 32'h1AA, 0, 1'b0, 32'hC0FF_8000, 8'h5A, 3, 1'b0, 1'b0,
                 3'd4, 1'b1, 1'b0, 2'd0);
        scenario("fail9", 1'b1, 32'h1AA, 0, 1'b0, 32'hC0FF_8000, 8'h5A, 9, 1'b0, 1'b0,
                 3'd5, 1'b1, 1'b0, 2'd0);
        scenario("fail7", 1'b1, 32'h1AA, 0, 1'b0, 32'hC0FF_8000, 8'h32, 7, 1'b0, 1'b0,
                 3'd6, 1'b1, 1'b0, 2'd2);
        summary();
    end
endmodule